// File: doc/BRIEF.md
# Frame-Sync Signaling Rate Switcher

This block sits beside one channel of an ADPCM codec and decides, once per sample, which coding rate the codec uses for that sample. It is clocked by the channel's bit clock and watches the frame sync input. Each time a frame sync pulse ends, it counts how many bit clocks the pulse was high and takes a snapshot of the three algorithm-select bits, the software/hardware mode flag and the compress/expand flag. From these it works out the effective rate for the coming frame.

A frame sync pulse that is two bit clocks wide marks a signaling frame. If 32 kbps is selected, that frame is coded at 24 kbps, which frees the least significant ADPCM bit to carry channel-associated signaling. The override covers that one frame only. The block also supplies the value of the pad bit that follows the 3-bit code at 24 kbps. A pulse three or more clocks wide is handled as a normal pulse and raises an error flag for that frame. Because the selection is read fresh at every sample boundary, the rate can change between samples with no reset.

Top module: `cas_rate_switch`

## Requirements
- R1: While `rst_n` is low and after it is released, `rate_code` is 0 (32 kbps) and `sig_frame`, `pad_bit` and `width_err` are 0 until the first frame sync pulse ends.
- R2: The rate code is 0 for 32 kbps, 1 for 24 kbps and 2 for 16 kbps. Select bits `alg_sel` = 3'b000 give code 0, 3'b111 give code 1 and 3'b101 give code 2 after a single-width pulse. Outputs update on the first clock edge at which frame sync is sampled low after being high.
- R3: Every other `alg_sel` value is handled as 32 kbps, and this includes the signaling override.
- R4: A two-clock frame sync pulse with 32 kbps selected gives rate code 1 and sets `sig_frame`. This happens with `sw_mode` at either 0 or 1.
- R5: A two-clock pulse with 24 kbps or 16 kbps selected leaves the selected rate unchanged, and `sig_frame` stays 0.
- R6: A pulse three or more clocks wide is handled as a normal pulse (no override, `sig_frame` 0) and sets `width_err` for that frame. The next pulse of legal width clears it.
- R7: The override lasts for one frame. The next single-width pulse with 32 kbps selected restores code 0 and clears `sig_frame`.
- R8: Between pulse ends, changes on `alg_sel`, `sw_mode` and `compress` have no effect on any output. They take effect at the next pulse end.
- R9: `pad_bit` is 1 only when `sw_mode`=1, `compress`=1 and `alg_sel`=3'b111. It is 0 in hardware mode, when expanding, and for a 24 kbps frame forced by signaling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Channel bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync, sampled on rising edge of clk |
| alg_sel | input | 3 | Algorithm select bits |
| sw_mode | input | 1 | 1 = software-configured mode, 0 = hardware-strapped mode |
| compress | input | 1 | 1 = compress, 0 = expand |
| rate_code | output | 2 | Effective rate for the current frame (0=32k, 1=24k, 2=16k) |
| sig_frame | output | 1 | Current frame is a signaling frame |
| pad_bit | output | 1 | Value of the bit that follows the 3-bit code at 24 kbps |
| width_err | output | 1 | Last frame sync pulse was wider than the signaling width |

## Verification
Every output is a single register, loaded on the clock edge that first samples frame sync low after a pulse. Results are therefore due one edge after the last high sample, and they then hold until the next pulse ends. The bench drives frame sync and the settings on falling edges and lets the pulse end. It samples on the falling edge after the updating rising edge, so every result is read half a cycle after it settles. For the hold requirement, the bench changes the settings between pulses and waits several cycles before reading. Any movement before the next pulse end is seen at the ports.

// File: rtl/cas_rate_pkg.sv
package cas_rate_pkg;

    typedef enum logic [1:0] {
        RATE_32 = 2'd0,
        RATE_24 = 2'd1,
        RATE_16 = 2'd2
    } rate_e;

    localparam logic [2:0] SEL_32 = 3'b000;
    localparam logic [2:0] SEL_24 = 3'b111;
    localparam logic [2:0] SEL_16 = 3'b101;

    typedef struct packed {
        rate_e rate;
        logic  sig;
        logic  pad;
        logic  err;
    } frame_cfg_t;

    localparam frame_cfg_t CFG_RESET = '{rate: RATE_32, sig: 1'b0, pad: 1'b0, err: 1'b0};

endpackage

// File: rtl/fs_width_meter.sv
module fs_width_meter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic             pulse_end,
    output logic [CNT_W-1:0] width
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (fsync) begin
            if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign width     = cnt_q;
    assign pulse_end = !fsync && (cnt_q != '0);

    // R6: width count climbs by one per high sample until it saturates
    a_r6_count_climbs: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && width != CNT_MAX) |=> (width == $past(width) + 1'b1));

    // R6: saturated count holds while the pulse continues
    a_r6_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && width == CNT_MAX) |=> (width == CNT_MAX));

endmodule

// File: rtl/rate_resolver.sv
module rate_resolver
    import cas_rate_pkg::*;
#(
    parameter int CNT_W     = 2,
    parameter int SIG_WIDTH = 2
) (
    input  logic [2:0]       alg_sel,
    input  logic             sw_mode,
    input  logic             compress,
    input  logic [CNT_W-1:0] width,
    output frame_cfg_t       cfg
);
    localparam logic [CNT_W-1:0] SIG_W = CNT_W'(SIG_WIDTH);

    rate_e sel_rate;
    logic  sel_is_32;
    logic  is_sig;
    logic  is_long;

    always_comb begin
        unique case (alg_sel)
            SEL_24:  sel_rate = RATE_24;
            SEL_16:  sel_rate = RATE_16;
            default: sel_rate = RATE_32;
        endcase
        sel_is_32 = (sel_rate == RATE_32);
        is_sig    = (width == SIG_W);
        is_long   = (width > SIG_W);

        cfg.rate = (sel_is_32 && is_sig) ? RATE_24 : sel_rate;
        cfg.sig  = sel_is_32 && is_sig;
        cfg.err  = is_long;
        cfg.pad  = sw_mode && compress && (alg_sel == SEL_24);
    end

endmodule

// File: rtl/cas_rate_switch.sv
module cas_rate_switch
    import cas_rate_pkg::*;
#(
    parameter int CNT_W     = 2,
    parameter int SIG_WIDTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fsync,
    input  logic [2:0] alg_sel,
    input  logic       sw_mode,
    input  logic       compress,
    output logic [1:0] rate_code,
    output logic       sig_frame,
    output logic       pad_bit,
    output logic       width_err
);
    logic             pulse_end;
    logic [CNT_W-1:0] width;
    frame_cfg_t       next_cfg;
    frame_cfg_t       cfg_d, cfg_q;

    fs_width_meter #(.CNT_W(CNT_W)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .pulse_end (pulse_end),
        .width     (width)
    );

    rate_resolver #(.CNT_W(CNT_W), .SIG_WIDTH(SIG_WIDTH)) u_resolve (
        .alg_sel  (alg_sel),
        .sw_mode  (sw_mode),
        .compress (compress),
        .width    (width),
        .cfg      (next_cfg)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (pulse_end) cfg_d = next_cfg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    assign rate_code = cfg_q.rate;
    assign sig_frame = cfg_q.sig;
    assign pad_bit   = cfg_q.pad;
    assign width_err = cfg_q.err;

    // R2: only three rate codes exist
    a_r2_rate_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rate_code != 2'd3);

    // R4: a signaling frame is always coded at 24 kbps
    a_r4_sig_is_24: assert property (@(posedge clk) disable iff (!rst_n)
        sig_frame |-> (rate_code == RATE_24));

    // R6: an over-wide pulse never yields a signaling frame
    a_r6_err_not_sig: assert property (@(posedge clk) disable iff (!rst_n)
        width_err |-> !sig_frame);

    // R9: pad bit only in a programmed (not forced) 24 kbps frame
    a_r9_pad_only_24: assert property (@(posedge clk) disable iff (!rst_n)
        pad_bit |-> (rate_code == RATE_24 && !sig_frame));

    // R8: outputs hold between pulse ends
    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_end |=> $stable({rate_code, sig_frame, pad_bit, width_err}));

endmodule

// File: tb/cas_rate_switch_test.sv
module cas_rate_switch_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fsync;
    logic [2:0] alg_sel;
    logic       sw_mode;
    logic       compress;
    logic [1:0] rate_code;
    logic       sig_frame;
    logic       pad_bit;
    logic       width_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    cas_rate_switch uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .alg_sel   (alg_sel),
        .sw_mode   (sw_mode),
        .compress  (compress),
        .rate_code (rate_code),
        .sig_frame (sig_frame),
        .pad_bit   (pad_bit),
        .width_err (width_err)
    );

    // vector: {alg[2:0], sw, comp, width[2:0], rate[1:0], sig, pad, err}
    localparam int NV = 15;
    localparam logic [12:0] VEC [0:NV-1] = '{
        {3'b000, 1'b1, 1'b1, 3'd1, 2'd0, 1'b0, 1'b0, 1'b0}, // R2 32k
        {3'b111, 1'b1, 1'b1, 3'd1, 2'd1, 1'b0, 1'b1, 1'b0}, // R2 R9 24k pad
        {3'b101, 1'b1, 1'b1, 3'd1, 2'd2, 1'b0, 1'b0, 1'b0}, // R2 16k
        {3'b000, 1'b1, 1'b1, 3'd2, 2'd1, 1'b1, 1'b0, 1'b0}, // R4 R9 forced 24, no pad
        {3'b000, 1'b0, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 1'b0}, // R7 restore
        {3'b000, 1'b0, 1'b0, 3'd2, 2'd1, 1'b1, 1'b0, 1'b0}, // R4 hardware mode
        {3'b111, 1'b1, 1'b1, 3'd2, 2'd1, 1'b0, 1'b1, 1'b0}, // R5 24k untouched
        {3'b101, 1'b0, 1'b1, 3'd2, 2'd2, 1'b0, 1'b0, 1'b0}, // R5 16k untouched
        {3'b111, 1'b0, 1'b1, 3'd1, 2'd1, 1'b0, 1'b0, 1'b0}, // R9 hardware mode
        {3'b111, 1'b1, 1'b0, 3'd1, 2'd1, 1'b0, 1'b0, 1'b0}, // R9 expanding
        {3'b010, 1'b1, 1'b1, 3'd1, 2'd0, 1'b0, 1'b0, 1'b0}, // R3 fallback
        {3'b010, 1'b1, 1'b1, 3'd2, 2'd1, 1'b1, 1'b0, 1'b0}, // R3 fallback override
        {3'b000, 1'b1, 1'b1, 3'd3, 2'd0, 1'b0, 1'b0, 1'b1}, // R6 wide pulse
        {3'b000, 1'b1, 1'b1, 3'd1, 2'd0, 1'b0, 1'b0, 1'b0}, // R6 error clears
        {3'b110, 1'b1, 1'b1, 3'd1, 2'd0, 1'b0, 1'b0, 1'b0}  // R3 fallback
    };

    task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: {rate,sig,pad,err} actual %b expected %b", req, got, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {rate_code, sig_frame, pad_bit, width_err};
    endfunction

    // pulse of w clocks; returns at the falling edge after the output update
    task automatic frame(input int w);
        @(negedge clk) fsync = 1'b1;
        for (int i = 1; i < w; i++) @(negedge clk);
        @(negedge clk) fsync = 1'b0;
        @(negedge clk);
    endtask

    task automatic gap();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; fsync = 1'b0; alg_sel = 3'b111; sw_mode = 1'b1; compress = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 during reset", outs(), 5'b00000);
        rst_n = 1'b1;
        gap();
        check("R1 after release", outs(), 5'b00000);

        for (int v = 0; v < NV; v++) begin
            alg_sel  = VEC[v][12:10];
            sw_mode  = VEC[v][9];
            compress = VEC[v][8];
            frame(int'(VEC[v][7:5]));
            check($sformatf("vector %0d", v), outs(), VEC[v][4:0]);
            gap();
        end

        // R8: settings changed between pulses do not move outputs
        alg_sel = 3'b111; sw_mode = 1'b1; compress = 1'b1;
        frame(1);
        check("R2 setup 24k", outs(), 5'b01010);
        @(negedge clk) alg_sel = 3'b101; sw_mode = 1'b0; compress = 1'b0;
        repeat (6) @(negedge clk);
        check("R8 hold after settings change", outs(), 5'b01010);
        frame(1);
        check("R8 new setting at pulse end", outs(), 5'b10000);

        // R8: output stays put during a pulse until it ends
        alg_sel = 3'b000;
        @(negedge clk) fsync = 1'b1;
        @(negedge clk);
        check("R8 no change mid pulse", outs(), 5'b10000);
        @(negedge clk) fsync = 1'b0;
        @(negedge clk);
        check("R4 signaling after split pulse", outs(), 5'b01100);
        gap();

        // R6: very wide pulse saturates count, still error
        frame(6);
        check("R6 six-clock pulse", outs(), 5'b00001);
        gap();

        // R7: override then single pulse, then again
        frame(2);
        check("R4 override again", outs(), 5'b01100);
        gap();
        frame(1);
        check("R7 one-frame override", outs(), 5'b00000);
        gap();

        // R1: reset mid-run clears state
        frame(2);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", outs(), 5'b00000);
        rst_n = 1'b1;
        gap();
        check("R1 stays after reset", outs(), 5'b00000);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule